// File: doc/BRIEF.md
# Free-Running System Timer with Compare Channels

A free-running up-counter with a set of compare channels behind a small 32-bit register port. The counter is twice as wide as one compare word. It advances by one on every clock edge where the external `tick` enable is high. Software reads it as two words: a low word and a high word. Each compare channel holds an absolute target for the low word. When the counter reaches that target, the channel's sticky match flag rises and drives the channel's own interrupt line.

To arm a channel, software reads the low word, adds a delta and writes the sum into the channel's compare register. The flag stays set until software writes a one to the matching bit of the status word. If a match and a clear reach the same bit in the same cycle, the match is kept. Reading the low word captures the high half at that instant, so a following read of the high word gives a consistent full-width value.

Top module: `sysclk_timer`

## Requirements
- R1: Word offsets are fixed. The status word is at 0x00, the low counter word at 0x04 and the high counter word at 0x08. Compare channel n is at 0x0C + 4*n. Read data appears on `bus_rdata` in the cycle after the read strobe is sampled.
- R2: The counter resets to zero. It increases by exactly one on each clock edge where `tick` is high and holds its value when `tick` is low.
- R3: The low word wraps from all-ones to zero. On that wrap it carries one into the high word, so the counter is 2*LO_W bits wide.
- R4: A read of the high word returns the high half as it stood when the low word was last read. Later counting does not change that value.
- R5: A channel matches on a `tick` edge where the incremented low word equals its compare value. Its flag (status bit n) is set on that edge, so it is visible in the same cycle the counter shows the target.
- R6: Writing the status word with bit n at one clears flag n on that edge. A zero in bit n leaves flag n unchanged.
- R7: If a match and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R8: `irq[n]` is high exactly while status bit n is set.
- R9: Every delta from 15 up to 2^LO_W - 1 ticks fires. This includes a target that is reached only after the low word wraps.
- R10: Addresses that are not word-aligned, and words beyond the last compare channel, read as zero. Writes to them change nothing.
- R11: Reset clears the counter, every compare register and every flag.
- R12: A compare register returns the low LO_W bits of the last value written to it, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from an external clock-enable source |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq | output | NUM_CMP | One interrupt line per compare channel |

## Verification
Each result has a fixed latency, and the checks sample at that latency:
- **Register reads:** data returns one edge after the read strobe. The scoreboard pops each expected word only in the cycle after the strobe was sampled.
- **Matches:** a flag and its interrupt line rise on the same edge that moves the counter onto the target. The bench waits until its own tick count sits one short of the target, checks that the line is still low, then checks that it is high one edge later.
- **Clears and the set-beats-clear case:** these are placed on the exact edge of a match and checked one edge afterwards.
- **Counter reads:** expected values come from a tick count the bench keeps itself.

// File: rtl/stimer_pkg.sv
package stimer_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned BUS_W    = 32;
   localparam int unsigned IDX_STAT = 0;
   localparam int unsigned IDX_LO   = 1;
   localparam int unsigned IDX_HI   = 2;
   localparam int unsigned IDX_CMP0 = 3;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_LO,
      SEL_HI,
      SEL_CMP
   } reg_sel_e;
endpackage

// File: rtl/stimer_counter.sv
module stimer_counter #(
   parameter int unsigned LO_W  = 32,
   parameter int unsigned CNT_W = 2 * LO_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_o,
   output logic [LO_W-1:0]  nxt_lo_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
   end

   // shared look-ahead value: every channel compares against it
   assign nxt_lo_o = cnt_q[LO_W-1:0] + 1'b1;
   assign cnt_o    = cnt_q;
endmodule

// File: rtl/stimer_chan.sv
module stimer_chan #(
   parameter int unsigned LO_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic [LO_W-1:0] nxt_lo,
   input  logic            cmp_we,
   input  logic [LO_W-1:0] cmp_wdata,
   input  logic            clr,
   output logic [LO_W-1:0] cmp_o,
   output logic            flag_o,
   output logic            hit_o
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [LO_W-1:0] cmp_q;
   logic            flag_q;
   logic            hit;

   assign hit = tick && (nxt_lo == cmp_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         flag_q <= 1'b0;
      end else begin
         if (cmp_we) cmp_q <= cmp_wdata;
         // a match in the clearing cycle keeps the flag
         flag_q <= hit | (flag_q & ~clr);
      end
   end

   assign cmp_o  = cmp_q;
   assign flag_o = flag_q;
   assign hit_o  = hit;
endmodule

// File: rtl/stimer_regif.sv
module stimer_regif
   import stimer_pkg::*;
#(
   parameter int unsigned LO_W    = 32,
   parameter int unsigned NUM_CMP = 4,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned CNT_W   = 2 * LO_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [BUS_W-1:0]   bus_wdata,
   input  logic [CNT_W-1:0]   cnt_i,
   input  logic [NUM_CMP-1:0] flags_i,
   input  logic [LO_W-1:0]    cmp_i [NUM_CMP],
   output logic [NUM_CMP-1:0] cmp_we_o,
   output logic [LO_W-1:0]    cmp_wdata_o,
   output logic [NUM_CMP-1:0] clr_o,
   output logic [BUS_W-1:0]   rdata_o
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned WORD_W = ADDR_W - 2;
   localparam int unsigned HI_W   = CNT_W - LO_W;

   logic [WORD_W-1:0] word;
   logic              aligned;
   reg_sel_e          sel;
   logic [BUS_W-1:0]  rd_mux;
   logic [BUS_W-1:0]  rdata_q;
   logic [HI_W-1:0]   hi_lat_q;

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);

   always_comb begin
      sel = SEL_NONE;
      if (aligned) begin
         if (word == WORD_W'(IDX_STAT))    sel = SEL_STAT;
         else if (word == WORD_W'(IDX_LO)) sel = SEL_LO;
         else if (word == WORD_W'(IDX_HI)) sel = SEL_HI;
         else if (word >= WORD_W'(IDX_CMP0) &&
                  word <  WORD_W'(IDX_CMP0 + NUM_CMP)) sel = SEL_CMP;
      end
   end

   assign cmp_wdata_o = bus_wdata[LO_W-1:0];

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_dec
      assign cmp_we_o[i] = bus_wr && (sel == SEL_CMP) &&
                           (word == WORD_W'(IDX_CMP0 + i));
      assign clr_o[i]    = bus_wr && (sel == SEL_STAT) && bus_wdata[i];
   end

   always_comb begin
      rd_mux = '0;
      unique case (sel)
         SEL_STAT: rd_mux = BUS_W'(flags_i);
         SEL_LO:   rd_mux = BUS_W'(cnt_i[LO_W-1:0]);
         SEL_HI:   rd_mux = BUS_W'(hi_lat_q);
         SEL_CMP: begin
            for (int i = 0; i < NUM_CMP; i++)
               if (word == WORD_W'(IDX_CMP0 + i)) rd_mux = BUS_W'(cmp_i[i]);
         end
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         hi_lat_q <= '0;
      end else if (bus_rd) begin
         rdata_q <= rd_mux;
         if (sel == SEL_LO) hi_lat_q <= cnt_i[CNT_W-1:LO_W];
      end
   end

   assign rdata_o = rdata_q;
endmodule

// File: rtl/sysclk_timer.sv
module sysclk_timer
   import stimer_pkg::*;
#(
   parameter int unsigned LO_W    = 32,
   parameter int unsigned NUM_CMP = 4,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [NUM_CMP-1:0] irq
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned CNT_W = 2 * LO_W;

   if (LO_W < 8 || LO_W > BUS_W) begin : g_bad_lo_w
      $error("sysclk_timer: LO_W must lie in 8..32");
   end
   if (NUM_CMP < 1 || NUM_CMP > 8) begin : g_bad_num
      $error("sysclk_timer: NUM_CMP must lie in 1..8");
   end
   if ((1 << (ADDR_W - 2)) <= (IDX_CMP0 + NUM_CMP)) begin : g_bad_addr
      $error("sysclk_timer: ADDR_W too narrow for the register set");
   end

   logic [CNT_W-1:0]   cnt_q;
   logic [LO_W-1:0]    nxt_lo;
   logic [LO_W-1:0]    cmp_v [NUM_CMP];
   logic [NUM_CMP-1:0] flag_v;
   logic [NUM_CMP-1:0] hit_v;
   logic [NUM_CMP-1:0] cmp_we;
   logic [NUM_CMP-1:0] clr;
   logic [LO_W-1:0]    cmp_wdata;

   stimer_counter #(.LO_W(LO_W), .CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cnt_o    (cnt_q),
      .nxt_lo_o (nxt_lo)
   );

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
      stimer_chan #(.LO_W(LO_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (tick),
         .nxt_lo    (nxt_lo),
         .cmp_we    (cmp_we[i]),
         .cmp_wdata (cmp_wdata),
         .clr       (clr[i]),
         .cmp_o     (cmp_v[i]),
         .flag_o    (flag_v[i]),
         .hit_o     (hit_v[i])
      );
   end

   stimer_regif #(
      .LO_W(LO_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
   ) u_rif (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_wr      (bus_wr),
      .bus_rd      (bus_rd),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .cnt_i       (cnt_q),
      .flags_i     (flag_v),
      .cmp_i       (cmp_v),
      .cmp_we_o    (cmp_we),
      .cmp_wdata_o (cmp_wdata),
      .clr_o       (clr),
      .rdata_o     (bus_rdata)
   );

   assign irq = flag_v;
endmodule

// File: rtl/stimer_checker.sv
module stimer_checker #(
   parameter int unsigned LO_W    = 32,
   parameter int unsigned NUM_CMP = 4,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned CNT_W   = 2 * LO_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               bus_wr,
   input logic               bus_rd,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [31:0]        bus_wdata,
   input logic [31:0]        bus_rdata,
   input logic [NUM_CMP-1:0] irq,
   input logic [CNT_W-1:0]   cnt_q,
   input logic [NUM_CMP-1:0] hit_v
);
   timeunit 1ns;
   timeprecision 100ps;

   logic stat_wr;
   logic unmapped;

   assign stat_wr  = bus_wr && (bus_addr == '0);
   assign unmapped = (bus_addr[1:0] != 2'b00) ||
                     (int'(bus_addr[ADDR_W-1:2]) > 2 + NUM_CMP);

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q)); // R2
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && unmapped) |=> bus_rdata == '0); // R10

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_a
      AST_MATCH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         hit_v[i] |=> irq[i]); // R5
      AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[i]) |-> $past(tick)); // R5
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (irq[i] && !(stat_wr && bus_wdata[i])) |=> irq[i]); // R6
      AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_v[i] && stat_wr && bus_wdata[i]) |=> irq[i]); // R7
      AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_wr && bus_wdata[i] && !hit_v[i]) |=> !irq[i]); // R6
   end
endmodule

bind sysclk_timer stimer_checker #(
   .LO_W(LO_W), .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .CNT_W(2 * LO_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .cnt_q     (cnt_q),
   .hit_v     (hit_v)
);

// File: tb/sim_sysclk_timer.sv
module sim_sysclk_timer;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int unsigned LW   = 12;
   localparam int unsigned NC   = 4;
   localparam int unsigned AW   = 8;
   localparam int unsigned CW   = 2 * LW;
   localparam logic [LW-1:0] LOMAX = '1;

   typedef struct {
      logic [31:0] exp;
      logic [31:0] mask;
      string       tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NC-1:0] irq;

   int            n_tests = 0;
   int            n_fail = 0;
   logic [CW-1:0] ref_cnt = '0;
   logic          rd_seen = 1'b0;
   item_t         sb_q[$];

   always #2.5 clk = ~clk;

   sysclk_timer #(.LO_W(LW), .NUM_CMP(NC), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq)
   );

   // reference tick count (R2, R3)
   always @(posedge clk) begin
      if (!rst_n)    ref_cnt <= '0;
      else if (tick) ref_cnt <= ref_cnt + 1'b1;
   end

   always @(posedge clk) rd_seen <= bus_rd;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: read data is due one edge after the strobe (R1)
   always @(negedge clk) begin
      if (rd_seen) begin
         if (sb_q.size() == 0) chk("R1 unexpected read data", bus_rdata, 32'hx);
         else begin
            item_t it;
            it = sb_q.pop_front();
            chk(it.tag, bus_rdata & it.mask, it.exp & it.mask);
         end
      end
   end

   // driver tasks: entered and left one time unit after a rising edge
   task automatic wr(logic [AW-1:0] a, logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [AW-1:0] a, logic [31:0] exp, logic [31:0] mask, string tag);
      item_t it;
      it.exp = exp; it.mask = mask; it.tag = tag;
      sb_q.push_back(it);
      bus_addr = a; bus_rd = 1'b1;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wait_lo(logic [LW-1:0] v);
      while (ref_cnt[LW-1:0] != v) begin @(posedge clk); #1; end
   endtask

   task automatic summary();
      idle(2);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [LW-1:0] tgt;
      logic [CW-1:0] snap;
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // R11 reset state, R1 offsets, tick held low
      rd(8'h00, 32'h0, '1, "R11 status after reset");
      rd(8'h04, 32'h0, '1, "R11 low word after reset");
      rd(8'h08, 32'h0, '1, "R1 high word after reset");
      for (int i = 0; i < NC; i++)
         rd(AW'(8'h0C + 4 * i), 32'h0, '1, "R11 compare after reset");
      chk("R8 irq low after reset", 32'(irq), 32'h0);

      // R12 compare readback, upper bits dropped
      for (int i = 0; i < NC; i++)
         wr(AW'(8'h0C + 4 * i), 32'hABCD_E700 + 32'(i));
      for (int i = 0; i < NC; i++)
         rd(AW'(8'h0C + 4 * i), 32'(LW'(32'hE700 + i)), '1, "R12 compare readback");

      // R2 counting with steady, gapped and absent tick
      tick = 1'b1;
      idle(10);
      rd(8'h04, 32'(ref_cnt[LW-1:0]), '1, "R2 count with tick high");
      tick = 1'b0;
      idle(1);
      snap = ref_cnt;
      idle(6);
      rd(8'h04, 32'(snap[LW-1:0]), '1, "R2 hold with tick low");
      for (int k = 0; k < 9; k++) begin tick = k[0]; idle(1); end
      tick = 1'b0;
      rd(8'h04, 32'(ref_cnt[LW-1:0]), '1, "R2 count with gapped tick");
      tick = 1'b1;

      // R5 R8 R9 smallest delta on channel 2
      wr(8'h00, 32'hF);
      tgt = ref_cnt[LW-1:0] + LW'(15);
      wr(8'h14, 32'(tgt));
      wait_lo(tgt - 1'b1);
      chk("R5 no flag one tick early", 32'(irq[2]), 32'h0);
      idle(1);
      chk("R5 R9 flag at target, delta 15", 32'(irq[2]), 32'h1);
      rd(8'h00, 32'h4, 32'h4, "R8 status bit matches irq");

      // R6 write-one-to-clear
      wr(8'h00, 32'h0);
      chk("R6 zero write keeps flag", 32'(irq[2]), 32'h1);
      wr(8'h00, 32'hB);
      chk("R6 other bits keep flag", 32'(irq[2]), 32'h1);
      wr(8'h00, 32'h4);
      chk("R6 one clears flag", 32'(irq[2]), 32'h0);
      rd(8'h00, 32'h0, 32'h4, "R8 status bit clear");

      // R7 set wins over a same-cycle clear on channel 1
      wr(8'h00, 32'hF);
      tgt = ref_cnt[LW-1:0] + LW'(40);
      wr(8'h10, 32'(tgt));
      wait_lo(tgt - 1'b1);
      chk("R7 flag clear before collision", 32'(irq[1]), 32'h0);
      wr(8'h00, 32'h2);
      chk("R7 match beats clear", 32'(irq[1]), 32'h1);

      // R9 R3 largest delta on channel 0, reached after a wrap
      wr(8'h00, 32'h1);
      tgt = ref_cnt[LW-1:0] + LOMAX;
      wr(8'h0C, 32'(tgt));
      idle(100);
      chk("R9 no early match on long delta", 32'(irq[0]), 32'h0);
      wait_lo(tgt - 1'b1);
      chk("R9 no match one tick before wrap target", 32'(irq[0]), 32'h0);
      idle(1);
      chk("R9 long delta fires after wrap", 32'(irq[0]), 32'h1);

      // R3 R4 carry into high word and latched high read
      wait_lo(LOMAX - LW'(5));
      snap = ref_cnt;
      rd(8'h04, 32'(snap[LW-1:0]), '1, "R4 low read before wrap");
      idle(20);
      rd(8'h08, 32'(snap[CW-1:LW]), '1, "R4 high word stays latched");
      snap = ref_cnt;
      rd(8'h04, 32'(snap[LW-1:0]), '1, "R3 low word wrapped");
      rd(8'h08, 32'(snap[CW-1:LW]), '1, "R3 high word carried");
      chk("R3 carry happened", 32'(snap[CW-1:LW] != 0), 32'h1);

      // R10 unmapped and misaligned accesses
      rd(8'h1C, 32'h0, '1, "R10 word past last channel");
      rd(8'h40, 32'h0, '1, "R10 far offset");
      rd(8'h06, 32'h0, '1, "R10 misaligned read");
      wr(8'h01, 32'hF);
      chk("R10 misaligned status write ignored", 32'(irq[0]), 32'h1);
      wr(8'h0D, 32'h777);
      wr(8'h1C, 32'h555);
      rd(8'h0C, 32'(tgt), '1, "R10 misaligned compare write ignored");

      // R11 reset during operation
      rst_n = 1'b0;
      tick = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
      chk("R11 irq cleared by reset", 32'(irq), 32'h0);
      rd(8'h00, 32'h0, '1, "R11 status cleared");
      rd(8'h04, 32'h0, '1, "R11 counter cleared");
      rd(8'h0C, 32'h0, '1, "R11 compare cleared");

      summary();
   end
endmodule